// File: doc/BRIEF.md
# Hybrid Group-Lookahead Prefix Adder

This block adds two unsigned binary words and a carry-in in a single pass of combinational logic. It returns the sum word and the carry-out. The operands are cut into equal slices of `GROUP` bits. Each slice reduces its per-bit generate and propagate terms to one group pair using flat lookahead logic. A parallel-prefix network then joins only these group pairs. The prefix results, merged with the external carry-in, give the carry that enters each slice. Every slice then forms its own sum bits with local lookahead from that carry.

The logic uses only AND, OR and XOR. Each prefix cell takes two pairs and merges them in a fixed order, with the higher-order pair first. A parameter selects the prefix network. One choice is a log-depth network with one cell per group per stage. The other is a linear chain that uses the fewest cells. Both give the same result. The block has no clock and holds no state. It is meant to sit inside a datapath stage, between the registers of the surrounding pipeline.

Top module: `hpa_adder`

## Requirements
- R1: For any inputs, {carry_o, sum_o} equals the 33-bit value a_i + b_i + carry_i.
- R2: When both operands are zero and carry_i is 1, sum_o is 1 and carry_o is 0. When carry_i is 0, both outputs are 0.
- R3: When both operands are all ones and carry_i is 1, sum_o is all ones and carry_o is 1.
- R4: When a_i XOR b_i is all ones, so that every bit propagates and none generates, carry_o equals carry_i and every bit of sum_o equals NOT carry_i.
- R5: The carry into slice k equals bit GROUP*k of the exact sum of the low GROUP*k operand bits plus carry_i. This holds for every slice boundary.
- R6: A carry made in the lowest bit passes through every slice to carry_o. All ones plus 1 with carry_i = 0 gives sum_o = 0 and carry_o = 1.
- R7: Swapping a_i and b_i does not change sum_o or carry_o.
- R8: The log-depth prefix network and the linear-chain network give identical outputs for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum word |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that must cross one particular slice boundary and no other. Random operands almost never line up a full run of propagating bits that ends exactly at a slice edge. The stimulus builds this case on purpose. For each boundary k, it sets the operand to a run of ones that fills the low k slices and adds 1. The carry must then leave slice k-1 and land as a single one at the base of slice k. The same inputs also drive a second instance built with the chain network, so the two prefix variants are compared on every vector.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

   // Generate / propagate pair carried between lookahead stages
   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // Prefix network variants
   localparam int PFX_LOGDEPTH = 0;
   localparam int PFX_CHAIN    = 1;

   // Ordered merge: hi covers the more significant span, lo the less
   function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

endpackage

// File: rtl/hpa_bit_gp.sv
module hpa_bit_gp #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] gen,
   output logic [WIDTH-1:0] prop
);
   // Level one: per-bit generate and propagate; XOR propagate is reused for the sum
   assign gen  = a & b;
   assign prop = a ^ b;
endmodule

// File: rtl/hpa_group_gp.sv
module hpa_group_gp
   import hpa_pkg::*;
#(
   parameter int GROUP = 4
) (
   input  logic [GROUP-1:0] gen,
   input  logic [GROUP-1:0] prop,
   output gp_t              grp
);
   // Level two: flat lookahead reduction of one slice
   always_comb begin
      logic g_acc;
      logic term;
      g_acc = 1'b0;
      for (int j = 0; j < GROUP; j++) begin
         term = gen[j];
         for (int m = j + 1; m < GROUP; m++) begin
            term = term & prop[m];
         end
         g_acc = g_acc | term;
      end
      grp.g = g_acc;
      grp.p = &prop;
   end
endmodule

// File: rtl/hpa_group_sum.sv
module hpa_group_sum #(
   parameter int GROUP = 4
) (
   input  logic [GROUP-1:0] gen,
   input  logic [GROUP-1:0] prop,
   input  logic             cin,
   output logic [GROUP-1:0] sum
);
   logic [GROUP-1:0] cin_bit;

   // Level five: each bit carry is a flat sum of products from the slice carry
   always_comb begin
      logic acc;
      logic term;
      for (int j = 0; j < GROUP; j++) begin
         term = cin;
         for (int m = 0; m < j; m++) begin
            term = term & prop[m];
         end
         acc = term;
         for (int k = 0; k < j; k++) begin
            term = gen[k];
            for (int m = k + 1; m < j; m++) begin
               term = term & prop[m];
            end
            acc = acc | term;
         end
         cin_bit[j] = acc;
      end
   end

   assign sum = prop ^ cin_bit;
endmodule

// File: rtl/hpa_prefix_net.sv
module hpa_prefix_net
   import hpa_pkg::*;
#(
   parameter int NGRP  = 8,
   parameter int STYLE = PFX_LOGDEPTH
) (
   input  gp_t [NGRP-1:0] grp,
   output gp_t [NGRP-1:0] pre
);
   localparam int STAGES = (NGRP > 1) ? $clog2(NGRP) : 1;

   generate
      if (STYLE == PFX_LOGDEPTH) begin : g_logdepth
         // Every stage merges each pair with the one 2**s places below it
         always_comb begin
            gp_t [NGRP-1:0] cur;
            gp_t [NGRP-1:0] nxt;
            cur = grp;
            for (int s = 0; s < STAGES; s++) begin
               for (int i = 0; i < NGRP; i++) begin
                  if (i >= (1 << s)) begin
                     nxt[i] = gp_merge(cur[i], cur[i - (1 << s)]);
                  end else begin
                     nxt[i] = cur[i];
                  end
               end
               cur = nxt;
            end
            pre = cur;
         end
      end else begin : g_chain
         // One cell per group, each waiting on the one below
         always_comb begin
            pre[0] = grp[0];
            for (int i = 1; i < NGRP; i++) begin
               pre[i] = gp_merge(grp[i], pre[i-1]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/hpa_adder.sv
module hpa_adder
   import hpa_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int GROUP = 4,
   parameter int STYLE = PFX_LOGDEPTH
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o
);
   localparam int NGRP = WIDTH / GROUP;

   generate
      if (GROUP < 1 || WIDTH < GROUP || (WIDTH % GROUP) != 0) begin : g_bad_split
         $error("hpa_adder: WIDTH must be a positive multiple of GROUP");
      end
      if (STYLE != PFX_LOGDEPTH && STYLE != PFX_CHAIN) begin : g_bad_style
         $error("hpa_adder: unknown prefix STYLE");
      end
   endgenerate

   logic [WIDTH-1:0] bit_g;
   logic [WIDTH-1:0] bit_p;
   gp_t  [NGRP-1:0]  grp_gp;
   gp_t  [NGRP-1:0]  pre_gp;
   logic [NGRP-1:0]  slice_cin;

   hpa_bit_gp #(.WIDTH(WIDTH)) u_bits (
      .a    (a_i),
      .b    (b_i),
      .gen  (bit_g),
      .prop (bit_p)
   );

   hpa_prefix_net #(.NGRP(NGRP), .STYLE(STYLE)) u_prefix (
      .grp (grp_gp),
      .pre (pre_gp)
   );

   // Level four: slice carry from the prefix below it and the external carry
   assign slice_cin[0] = carry_i;

   genvar k;
   generate
      for (k = 1; k < NGRP; k++) begin : g_cin
         assign slice_cin[k] = pre_gp[k-1].g | (pre_gp[k-1].p & carry_i);
      end

      for (k = 0; k < NGRP; k++) begin : g_slice
         hpa_group_gp #(.GROUP(GROUP)) u_ggp (
            .gen  (bit_g[k*GROUP +: GROUP]),
            .prop (bit_p[k*GROUP +: GROUP]),
            .grp  (grp_gp[k])
         );
         hpa_group_sum #(.GROUP(GROUP)) u_gsum (
            .gen  (bit_g[k*GROUP +: GROUP]),
            .prop (bit_p[k*GROUP +: GROUP]),
            .cin  (slice_cin[k]),
            .sum  (sum_o[k*GROUP +: GROUP])
         );
      end
   endgenerate

   assign carry_o = pre_gp[NGRP-1].g | (pre_gp[NGRP-1].p & carry_i);
endmodule

// File: rtl/hpa_adder_chk.sv
module hpa_adder_chk #(
   parameter int WIDTH = 32,
   parameter int GROUP = 4
) (
   input logic [WIDTH-1:0]       a_i,
   input logic [WIDTH-1:0]       b_i,
   input logic                   carry_i,
   input logic [WIDTH-1:0]       sum_o,
   input logic                   carry_o,
   input logic [WIDTH/GROUP-1:0] slice_cin
);
   localparam int NGRP = WIDTH / GROUP;

   logic [WIDTH:0] ref_full;
   assign ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};

   always_comb begin
      a_r1_sum_exact: assert ({carry_o, sum_o} == ref_full)
         else $error("R1 sum mismatch");
   end

   always_comb begin
      if (a_i == '0 && b_i == '0) begin
         a_r2_zero_operands: assert (sum_o == {{(WIDTH-1){1'b0}}, carry_i} && carry_o == 1'b0)
            else $error("R2 zero operand result wrong");
      end
   end

   always_comb begin
      if ((a_i ^ b_i) == '1) begin
         a_r4_all_propagate: assert (carry_o == carry_i && sum_o == {WIDTH{~carry_i}})
            else $error("R4 all-propagate result wrong");
      end
   end

   always_comb begin
      logic [WIDTH:0] mask;
      logic [WIDTH:0] part;
      for (int k = 1; k < NGRP; k++) begin
         mask = ({{WIDTH{1'b0}}, 1'b1} << (k*GROUP)) - 1'b1;
         part = ({1'b0, a_i} & mask) + ({1'b0, b_i} & mask) + {{WIDTH{1'b0}}, carry_i};
         a_r5_slice_carry: assert (slice_cin[k] == part[k*GROUP])
            else $error("R5 slice carry wrong at slice %0d", k);
      end
   end
endmodule

bind hpa_adder hpa_adder_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
   .a_i       (a_i),
   .b_i       (b_i),
   .carry_i   (carry_i),
   .sum_o     (sum_o),
   .carry_o   (carry_o),
   .slice_cin (slice_cin)
);

// File: tb/hpa_adder_test.sv
module hpa_adder_test;
   import hpa_pkg::*;

   localparam int W = 32;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0] a, b;
   logic         cin;
   logic [W-1:0] sum, sum_ch;
   logic         cout, cout_ch;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   hpa_adder #(.WIDTH(W), .GROUP(4), .STYLE(PFX_LOGDEPTH)) uut (
      .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum), .carry_o(cout)
   );

   hpa_adder #(.WIDTH(W), .GROUP(4), .STYLE(PFX_CHAIN)) uut_chain (
      .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum_ch), .carry_o(cout_ch)
   );

   typedef struct packed {
      logic [W-1:0] va;
      logic [W-1:0] vb;
      logic         vc;
      logic [W:0]   vexp;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VEC [NVEC] = '{
      '{32'h0000_0000, 32'h0000_0000, 1'b0, 33'h0_0000_0000},
      '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 33'h1_0000_0000},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF},
      '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF},
      '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 33'h1_0000_0000},
      '{32'h0000_000F, 32'h0000_0001, 1'b0, 33'h0_0000_0010},
      '{32'h1234_5678, 32'h8765_4321, 1'b0, 33'h0_9999_9999},
      '{32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 33'h1_FFFF_FFFE},
      '{32'h0FFF_FFFF, 32'h0000_0001, 1'b0, 33'h0_1000_0000}
   };

   task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
      @(negedge clk);
      a   = va;
      b   = vb;
      cin = vc;
      #2;
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      #2;
      // R2: idle inputs give an all-zero result
      check("R2 idle", {cout, sum}, 33'h0);

      // R1: vector table
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i].va, VEC[i].vb, VEC[i].vc);
         check("R1 table", {cout, sum}, VEC[i].vexp);
         check("R8 table", {cout_ch, sum_ch}, VEC[i].vexp);
      end

      // R2: zero operands with carry-in
      apply('0, '0, 1'b1);
      check("R2 carry only", {cout, sum}, 33'h0_0000_0001);

      // R3: all ones plus carry-in
      apply('1, '1, 1'b1);
      check("R3 all ones", {cout, sum}, 33'h1_FFFF_FFFF);

      // R4: all-propagate, both carry-in values
      apply(32'hF0F0_3C3C, 32'h0F0F_C3C3, 1'b0);
      check("R4 prop cin0", {cout, sum}, 33'h0_FFFF_FFFF);
      apply(32'hF0F0_3C3C, 32'h0F0F_C3C3, 1'b1);
      check("R4 prop cin1", {cout, sum}, 33'h1_0000_0000);

      // R6: carry from bit 0 ripples to the top
      apply('1, 32'h0000_0001, 1'b0);
      check("R6 full ripple", {cout, sum}, 33'h1_0000_0000);

      // R5: carry crossing exactly one slice boundary
      for (int k = 1; k < 8; k++) begin
         logic [W-1:0] run;
         run = (32'h1 << (4*k)) - 32'h1;
         apply(run, 32'h0000_0001, 1'b0);
         check("R5 boundary", {cout, sum}, {1'b0, 32'h1 << (4*k)});
         apply(run, 32'h0000_0000, 1'b1);
         check("R5 boundary cin", {cout, sum}, {1'b0, 32'h1 << (4*k)});
      end

      // R1 / R7 / R8: random operands, then swapped
      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] ra, rb;
         logic         rc;
         logic [W:0]   ex;
         ra = $urandom;
         rb = $urandom;
         rc = 1'($urandom);
         ex = {1'b0, ra} + {1'b0, rb} + {32'h0, rc};
         apply(ra, rb, rc);
         check("R1 random", {cout, sum}, ex);
         check("R8 random", {cout_ch, sum_ch}, {cout, sum});
         apply(rb, ra, rc);
         check("R7 swapped", {cout, sum}, ex);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule